// File: doc/BRIEF.md
# Reclocker Output Routing Selector

This block sits between the two serial receivers, the clock-data-recovery loop and the two output drivers of a reclocker. It picks which input feeds which output, powers down the paths that are not in use, and decides what each output carries: retimed data, raw (non-retimed) data, a full-rate line clock, a divided clock, a 10 MHz reference clock, or nothing (muted). Data and clock streams arrive as DW-bit parallel samples per core clock, and every output is registered.

Content is normally chosen by one shared 2-bit mode that covers both outputs and reacts to the lock flag and to the data-rate class. Setting the override bit replaces the shared mode with an independent 3-bit select for each output. A per-input force-off control can hold an input's signal detect low, which shuts the recovery loop and both outputs down when that input is the selected one. An invert bit flips the polarity of the second output's data.

Top module: `rclk_route_sel`

## Requirements
- R1: Route select picks the source input and output power-down: 00 uses input 0 with both outputs up; 01 uses input 0 with output 1 powered down; 10 uses input 1 with output 0 powered down; 11 uses input 1 with both outputs up. Bit 1 of the route select names the input.
- R2: The effective detect of an input is its signal detect AND NOT its force-off. When the selected input's effective detect is low, cdr_pd, o0_pd and o1_pd are all 1 and both outputs are muted.
- R3: With override clear, shared mode 00 mutes both outputs and shared mode 11 drives raw data of the selected input on both outputs regardless of lock.
- R4: With override clear, shared mode 10 drives retimed data on both outputs when locked and raw data when unlocked.
- R5: With override clear, shared mode 01 drives output 0 like R4; output 1 carries the line clock when locked and rate_hi is 0, the divided clock when locked and rate_hi is 1, and is muted when unlocked.
- R6: With override set, output 0 select 000 mutes, 010 gives raw data, 100 gives retimed data when locked and mute when unlocked; codes 011, 101, 110 and 111 mute the output.
- R7: With override set, output 1 select 111 mutes, 000 gives raw data, 001 retimed data, 010 the line clock, 101 the reference clock when o1_div_pick is 0 and the divided clock when it is 1; codes 011, 100 and 110 mute the output.
- R8: With override set, output 0 select 001 gives the reference clock only while output 1 select is 101 with o1_div_pick 0; otherwise output 0 is muted. Lock is not required.
- R9: When o1_invert is 1, every bit of the data driven on output 1 is inverted; a muted output 1 still drives zero.
- R10: A muted or powered-down output has its enable at 0 and its data at all zeros; a driving output has its enable at 1.
- R11: All outputs are registered: a change on any input shows at the outputs after the next rising clock edge. During reset, enables and data are 0 and all power-downs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_in | input | 2 | Signal detect per input |
| force_off | input | 2 | Force each input's detect low |
| cdr_lock | input | 1 | Recovery loop locked |
| rate_hi | input | 1 | Locked rate class is above 3 Gbps |
| raw0_dat | input | DW | Raw data samples from input 0 |
| raw1_dat | input | DW | Raw data samples from input 1 |
| rtm_dat | input | DW | Retimed data samples |
| line_clk | input | DW | Full-rate line clock pattern |
| div_clk | input | DW | Divided clock pattern |
| ref_clk | input | DW | 10 MHz reference clock pattern |
| route_sel | input | 2 | Input-to-output route select |
| share_mode | input | 2 | Shared output mode |
| ovr_en | input | 1 | Use per-output selects |
| o0_sel | input | 3 | Output 0 select under override |
| o1_sel | input | 3 | Output 1 select under override |
| o1_div_pick | input | 1 | Output 1 code 101: 1 divided, 0 reference |
| o1_invert | input | 1 | Invert output 1 data |
| o0_dat | output | DW | Output 0 data |
| o1_dat | output | DW | Output 1 data |
| o0_en | output | 1 | Output 0 driving (0 = muted) |
| o1_en | output | 1 | Output 1 driving (0 = muted) |
| o0_pd | output | 1 | Output 0 powered down |
| o1_pd | output | 1 | Output 1 powered down |
| cdr_pd | output | 1 | Recovery loop powered down |

## Verification
The bench builds the block with DW at 3, which keeps each stream narrow enough that the content of a vector is fully determined while still telling the six sources apart in most cycles. At that width every combination of route, both detects, both force-offs, lock, rate class, shared mode, all 64 override select pairs, the divided-clock pick and the invert bit is applied, one vector per clock with the streams changing every cycle. This reaches the invalid select codes, the reference-clock pairing rule and the unlocked retimed case on both outputs.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // Content an output can carry
   typedef enum logic [2:0] {
      SRC_MUTE = 3'd0,
      SRC_RAW  = 3'd1,
      SRC_RET  = 3'd2,
      SRC_LINE = 3'd3,
      SRC_DIV  = 3'd4,
      SRC_REF  = 3'd5
   } src_e;

   localparam int SEL_W  = 3;
   localparam int MODE_W = 2;
   localparam int NOUT   = 2;

   // Shared mode codes
   localparam logic [MODE_W-1:0] SM_MUTE  = 2'b00;
   localparam logic [MODE_W-1:0] SM_CLK   = 2'b01;
   localparam logic [MODE_W-1:0] SM_DATA  = 2'b10;
   localparam logic [MODE_W-1:0] SM_RAW   = 2'b11;

   // Output 0 override codes
   localparam logic [SEL_W-1:0] O0_MUTE = 3'b000;
   localparam logic [SEL_W-1:0] O0_REF  = 3'b001;
   localparam logic [SEL_W-1:0] O0_RAW  = 3'b010;
   localparam logic [SEL_W-1:0] O0_RET  = 3'b100;

   // Output 1 override codes
   localparam logic [SEL_W-1:0] O1_RAW  = 3'b000;
   localparam logic [SEL_W-1:0] O1_RET  = 3'b001;
   localparam logic [SEL_W-1:0] O1_LINE = 3'b010;
   localparam logic [SEL_W-1:0] O1_CLK  = 3'b101;
   localparam logic [SEL_W-1:0] O1_MUTE = 3'b111;

endpackage

// File: rtl/rcs_in_pick.sv
module rcs_in_pick
   import rcs_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic [1:0]    sd_in,
   input  logic [1:0]    force_off,
   input  logic [1:0]    route_sel,
   input  logic [DW-1:0] raw0_dat,
   input  logic [DW-1:0] raw1_dat,
   output logic [DW-1:0] raw_pick,
   output logic          path_up,
   output logic [NOUT-1:0] out_pd
);

   logic [1:0] det_eff;
   logic       in_idx;

   assign det_eff  = sd_in & ~force_off;
   assign in_idx   = route_sel[1];
   assign raw_pick = in_idx ? raw1_dat : raw0_dat;
   assign path_up  = det_eff[in_idx];

   always_comb begin
      out_pd = {NOUT{~path_up}};
      unique case (route_sel)
         2'b01:   out_pd[1] = 1'b1;
         2'b10:   out_pd[0] = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/rcs_src_dec.sv
module rcs_src_dec
   import rcs_pkg::*;
#(
   parameter int OUT_IDX = 0
) (
   input  logic              ovr_en,
   input  logic [MODE_W-1:0] share_mode,
   input  logic [SEL_W-1:0]  o0_sel,
   input  logic [SEL_W-1:0]  o1_sel,
   input  logic              o1_div_pick,
   input  logic              cdr_lock,
   input  logic              rate_hi,
   output src_e              src
);

   if (OUT_IDX < 0 || OUT_IDX >= NOUT) begin : g_bad_idx
      $error("rcs_src_dec: OUT_IDX out of range");
   end

   src_e data_lk;
   assign data_lk = cdr_lock ? SRC_RET : SRC_RAW;

   if (OUT_IDX == 0) begin : g_out0
      logic ref_pair;
      assign ref_pair = (o1_sel == O1_CLK) && !o1_div_pick;

      always_comb begin
         src = SRC_MUTE;
         if (!ovr_en) begin
            unique case (share_mode)
               SM_MUTE: src = SRC_MUTE;
               SM_CLK:  src = data_lk;
               SM_DATA: src = data_lk;
               SM_RAW:  src = SRC_RAW;
               default: src = SRC_MUTE;
            endcase
         end else begin
            unique case (o0_sel)
               O0_MUTE: src = SRC_MUTE;
               O0_REF:  src = ref_pair ? SRC_REF : SRC_MUTE;
               O0_RAW:  src = SRC_RAW;
               O0_RET:  src = cdr_lock ? SRC_RET : SRC_MUTE;
               default: src = SRC_MUTE;
            endcase
         end
      end
   end else begin : g_out1
      always_comb begin
         src = SRC_MUTE;
         if (!ovr_en) begin
            unique case (share_mode)
               SM_MUTE: src = SRC_MUTE;
               SM_CLK:  src = !cdr_lock ? SRC_MUTE :
                              (rate_hi ? SRC_DIV : SRC_LINE);
               SM_DATA: src = data_lk;
               SM_RAW:  src = SRC_RAW;
               default: src = SRC_MUTE;
            endcase
         end else begin
            unique case (o1_sel)
               O1_MUTE: src = SRC_MUTE;
               O1_RAW:  src = SRC_RAW;
               O1_RET:  src = SRC_RET;
               O1_LINE: src = SRC_LINE;
               O1_CLK:  src = o1_div_pick ? SRC_DIV : SRC_REF;
               default: src = SRC_MUTE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rcs_drive.sv
module rcs_drive
   import rcs_pkg::*;
#(
   parameter int DW     = 4,
   parameter bit INV_OK = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  src_e          src,
   input  logic          pd,
   input  logic          inv,
   input  logic [DW-1:0] raw_dat,
   input  logic [DW-1:0] rtm_dat,
   input  logic [DW-1:0] line_clk,
   input  logic [DW-1:0] div_clk,
   input  logic [DW-1:0] ref_clk,
   output logic [DW-1:0] dat_q,
   output logic          en_q,
   output logic          pd_q
);

   logic [DW-1:0] payload;
   logic [DW-1:0] inv_mask;
   logic [DW-1:0] dat_d;
   logic          en_d;

   always_comb begin
      payload = '0;
      unique case (src)
         SRC_RAW:  payload = raw_dat;
         SRC_RET:  payload = rtm_dat;
         SRC_LINE: payload = line_clk;
         SRC_DIV:  payload = div_clk;
         SRC_REF:  payload = ref_clk;
         default:  payload = '0;
      endcase
   end

   if (INV_OK) begin : g_inv
      assign inv_mask = {DW{inv}};
   end else begin : g_noinv
      logic unused_inv;
      assign unused_inv = inv;
      assign inv_mask   = '0;
   end

   assign en_d  = (src != SRC_MUTE) && !pd;
   assign dat_d = en_d ? (payload ^ inv_mask) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
         en_q  <= 1'b0;
         pd_q  <= 1'b1;
      end else begin
         dat_q <= dat_d;
         en_q  <= en_d;
         pd_q  <= pd;
      end
   end

endmodule

// File: rtl/rclk_route_sel.sv
module rclk_route_sel
   import rcs_pkg::*;
#(
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sd_in,
   input  logic [1:0]    force_off,
   input  logic          cdr_lock,
   input  logic          rate_hi,
   input  logic [DW-1:0] raw0_dat,
   input  logic [DW-1:0] raw1_dat,
   input  logic [DW-1:0] rtm_dat,
   input  logic [DW-1:0] line_clk,
   input  logic [DW-1:0] div_clk,
   input  logic [DW-1:0] ref_clk,
   input  logic [1:0]    route_sel,
   input  logic [1:0]    share_mode,
   input  logic          ovr_en,
   input  logic [2:0]    o0_sel,
   input  logic [2:0]    o1_sel,
   input  logic          o1_div_pick,
   input  logic          o1_invert,
   output logic [DW-1:0] o0_dat,
   output logic [DW-1:0] o1_dat,
   output logic          o0_en,
   output logic          o1_en,
   output logic          o0_pd,
   output logic          o1_pd,
   output logic          cdr_pd
);

   if (DW < 1 || DW > 64) begin : g_bad_dw
      $error("rclk_route_sel: DW must be 1..64");
   end

   logic [DW-1:0]   raw_pick;
   logic            path_up;
   logic [NOUT-1:0] out_pd;
   logic [DW-1:0]   dat_q [NOUT];
   logic [NOUT-1:0] en_q;
   logic [NOUT-1:0] pd_q;
   logic [NOUT-1:0] inv_v;

   assign inv_v = {o1_invert, 1'b0};

   rcs_in_pick #(.DW(DW)) u_pick (
      .sd_in     (sd_in),
      .force_off (force_off),
      .route_sel (route_sel),
      .raw0_dat  (raw0_dat),
      .raw1_dat  (raw1_dat),
      .raw_pick  (raw_pick),
      .path_up   (path_up),
      .out_pd    (out_pd)
   );

   for (genvar g = 0; g < NOUT; g++) begin : g_out
      src_e src;

      rcs_src_dec #(.OUT_IDX(g)) u_dec (
         .ovr_en      (ovr_en),
         .share_mode  (share_mode),
         .o0_sel      (o0_sel),
         .o1_sel      (o1_sel),
         .o1_div_pick (o1_div_pick),
         .cdr_lock    (cdr_lock),
         .rate_hi     (rate_hi),
         .src         (src)
      );

      rcs_drive #(.DW(DW), .INV_OK(g == 1)) u_drv (
         .clk      (clk),
         .rst_n    (rst_n),
         .src      (src),
         .pd       (out_pd[g]),
         .inv      (inv_v[g]),
         .raw_dat  (raw_pick),
         .rtm_dat  (rtm_dat),
         .line_clk (line_clk),
         .div_clk  (div_clk),
         .ref_clk  (ref_clk),
         .dat_q    (dat_q[g]),
         .en_q     (en_q[g]),
         .pd_q     (pd_q[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cdr_pd <= 1'b1;
      else        cdr_pd <= !path_up;
   end

   assign o0_dat = dat_q[0];
   assign o1_dat = dat_q[1];
   assign o0_en  = en_q[0];
   assign o1_en  = en_q[1];
   assign o0_pd  = pd_q[0];
   assign o1_pd  = pd_q[1];

endmodule

// File: rtl/rcs_chk.sv
module rcs_chk #(
   parameter int DW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    sd_in,
   input logic [1:0]    force_off,
   input logic          cdr_lock,
   input logic [1:0]    route_sel,
   input logic [1:0]    share_mode,
   input logic          ovr_en,
   input logic [2:0]    o0_sel,
   input logic [2:0]    o1_sel,
   input logic          o1_div_pick,
   input logic [DW-1:0] o0_dat,
   input logic [DW-1:0] o1_dat,
   input logic          o0_en,
   input logic          o1_en,
   input logic          o0_pd,
   input logic          o1_pd,
   input logic          cdr_pd
);

   // R1
   route_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_sel == 2'b10) |=> (o0_pd && !o0_en));

   // R2
   lost_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sd_in[route_sel[1]] && !force_off[route_sel[1]])
      |=> (cdr_pd && o0_pd && o1_pd && !o0_en && !o1_en));

   // R3
   shared_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && share_mode == 2'b00) |=> (!o0_en && !o1_en));

   // R5
   clk_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_en && share_mode == 2'b01 && !cdr_lock) |=> !o1_en);

   // R6
   ret_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_en && o0_sel == 3'b100 && !cdr_lock) |=> !o0_en);

   // R8
   ref_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_en && o0_sel == 3'b001 && !(o1_sel == 3'b101 && !o1_div_pick))
      |=> !o0_en);

   // R10
   mute_zero0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !o0_en |-> (o0_dat == '0));

   // R10
   mute_zero1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !o1_en |-> (o1_dat == '0));

endmodule

bind rclk_route_sel rcs_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sd_in       (sd_in),
   .force_off   (force_off),
   .cdr_lock    (cdr_lock),
   .route_sel   (route_sel),
   .share_mode  (share_mode),
   .ovr_en      (ovr_en),
   .o0_sel      (o0_sel),
   .o1_sel      (o1_sel),
   .o1_div_pick (o1_div_pick),
   .o0_dat      (o0_dat),
   .o1_dat      (o1_dat),
   .o0_en       (o0_en),
   .o1_en       (o1_en),
   .o0_pd       (o0_pd),
   .o1_pd       (o1_pd),
   .cdr_pd      (cdr_pd)
);

// File: tb/sim_rclk_route_sel.sv
module sim_rclk_route_sel;

   localparam int DW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    sd_in = '0, force_off = '0, route_sel = '0, share_mode = '0;
   logic          cdr_lock = 1'b0, rate_hi = 1'b0, ovr_en = 1'b0;
   logic          o1_div_pick = 1'b0, o1_invert = 1'b0;
   logic [2:0]    o0_sel = '0, o1_sel = '0;
   logic [DW-1:0] raw0_dat = '0, raw1_dat = '0, rtm_dat = '0;
   logic [DW-1:0] line_clk = '0, div_clk = '0, ref_clk = '0;
   logic [DW-1:0] o0_dat, o1_dat;
   logic          o0_en, o1_en, o0_pd, o1_pd, cdr_pd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rclk_route_sel #(.DW(DW)) u0 (.*);

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_reset();
      chk("R11", "reset o0_en", o0_en, 0);
      chk("R11", "reset o1_en", o1_en, 0);
      chk("R11", "reset o0_dat", o0_dat, 0);
      chk("R11", "reset o1_dat", o1_dat, 0);
      chk("R11", "reset pd", {cdr_pd, o0_pd, o1_pd}, 3'b111);
   endtask

   // Source codes: 0 mute, 1 raw, 2 retimed, 3 line, 4 divided, 5 ref
   function automatic logic [DW-1:0] pay(input int s, input logic [DW-1:0] raw);
      case (s)
         1: return raw;
         2: return rtm_dat;
         3: return line_clk;
         4: return div_clk;
         5: return ref_clk;
         default: return '0;
      endcase
   endfunction

   initial begin
      logic [DW-1:0] e_d0, e_d1;
      logic          e_en0, e_en1, e_pd0, e_pd1, e_cpd;
      string         t0, t1;
      bit            have;
      have = 1'b0;
      e_d0 = '0; e_d1 = '0; e_en0 = 0; e_en1 = 0;
      e_pd0 = 1; e_pd1 = 1; e_cpd = 1; t0 = ""; t1 = "";

      repeat (3) @(negedge clk);
      chk_reset();
      rst_n = 1'b1;

      for (int n = 0; n < 256 * 264; n++) begin
         int i, c, cc, t, s0, s1;
         bit act, sin;
         logic [DW-1:0] rp;
         @(negedge clk);
         if (have) begin
            chk("R1", "cdr/out pd", {cdr_pd, o0_pd, o1_pd}, {e_cpd, e_pd0, e_pd1});
            chk(t0, "o0 en/dat", {o0_en, o0_dat}, {e_en0, e_d0});
            chk(t1, "o1 en/dat", {o1_en, o1_dat}, {e_en1, e_d1});
            if (!o0_en || !o1_en)
               chk("R10", "muted data", (o0_en ? 0 : o0_dat) | (o1_en ? 0 : o1_dat), 0);
         end
         c = n % 264;
         i = n / 264;
         route_sel = 2'(i % 4);
         sd_in     = 2'((i / 4) % 4);
         force_off = 2'((i / 16) % 4);
         cdr_lock  = 1'((i / 64) % 2);
         rate_hi   = 1'((i / 128) % 2);
         o1_invert = 1'(c % 2);
         cc = c / 2;
         if (cc < 4) begin
            ovr_en = 0; share_mode = 2'(cc);
            o0_sel = 3'((n / 7) % 8); o1_sel = 3'((n / 3) % 8); o1_div_pick = 1'(n % 3 == 0);
         end else begin
            t = cc - 4;
            ovr_en = 1; share_mode = 2'(n % 4);
            o0_sel = 3'(t % 8); o1_sel = 3'((t / 8) % 8); o1_div_pick = 1'(t / 64);
         end
         raw0_dat = DW'(n);         raw1_dat = DW'(n * 3 + 1);
         rtm_dat  = DW'(n * 5 + 2); line_clk = DW'(n * 7 + 3);
         div_clk  = DW'(n ^ 5);     ref_clk  = DW'(~n);

         // Expected values
         sin = route_sel[1];
         act = sd_in[sin] && !force_off[sin];
         rp  = sin ? raw1_dat : raw0_dat;
         e_cpd = !act;
         e_pd0 = !act || route_sel == 2'b10;
         e_pd1 = !act || route_sel == 2'b01;
         if (!ovr_en) begin
            case (share_mode)
               2'b00: begin s0 = 0; s1 = 0; t0 = "R3"; t1 = "R3"; end
               2'b01: begin s0 = cdr_lock ? 2 : 1;
                            s1 = cdr_lock ? (rate_hi ? 4 : 3) : 0; t0 = "R5"; t1 = "R5"; end
               2'b10: begin s0 = cdr_lock ? 2 : 1; s1 = s0; t0 = "R4"; t1 = "R4"; end
               default: begin s0 = 1; s1 = 1; t0 = "R3"; t1 = "R3"; end
            endcase
         end else begin
            t0 = "R6"; t1 = "R7";
            case (o0_sel)
               3'b010: s0 = 1;
               3'b100: s0 = cdr_lock ? 2 : 0;
               3'b001: begin s0 = (o1_sel == 3'b101 && !o1_div_pick) ? 5 : 0; t0 = "R8"; end
               default: s0 = 0;
            endcase
            case (o1_sel)
               3'b000: s1 = 1;
               3'b001: s1 = 2;
               3'b010: s1 = 3;
               3'b101: s1 = o1_div_pick ? 4 : 5;
               default: s1 = 0;
            endcase
         end
         if (e_cpd) begin t0 = "R2"; t1 = "R2"; end
         else if (o1_invert && s1 != 0 && !e_pd1) t1 = "R9";
         e_en0 = (s0 != 0) && !e_pd0;
         e_en1 = (s1 != 0) && !e_pd1;
         e_d0  = e_en0 ? pay(s0, rp) : '0;
         e_d1  = e_en1 ? (pay(s1, rp) ^ {DW{o1_invert}}) : '0;
         have  = 1'b1;
      end
      @(negedge clk);
      chk(t0, "last o0", {o0_en, o0_dat}, {e_en0, e_d0});
      chk(t1, "last o1", {o1_en, o1_dat}, {e_en1, e_d1});

      // R11: reset returns the reset state
      rst_n = 1'b0;
      @(negedge clk);
      chk_reset();

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule